// File: doc/BRIEF.md
# Debug Control and Event Gating Unit

This unit sits beside a processor core. It holds the debug control word and the debug status word. Two agents can write them: the processor's own software bus and an external debugger port. The control word decides which of five debug events the unit records: instruction-complete, branch-taken, interrupt-taken, trap and instruction-address-compare-1. It also decides whether recorded events raise a debug interrupt, and whether the processor's reset-out pin is driven.

The debugger has priority over software. A debugger-mode flag in the control word can be set only from the debugger port. While the flag is set:
- software writes are dropped unless a per-register permission input allows them;
- the programmed state survives a processor reset;
- recorded events never interrupt the core.

Events arrive as single-cycle strobes. Both words are visible on output ports, and unimplemented bits read as zero.

Top module: `dbg_gate_top`

## Requirements
- R1: The debugger-mode flag (control bit 31, the MSB) changes only through a debugger-port write to the control word (`dbgSel`=0). Software writes leave it unchanged.
- R2: When a debugger-port write moves the debugger-mode flag from 0 to 1, the other control bits keep their previous values, whatever the write data holds.
- R3: While debugger mode is 1, a software write to the control word (`swSel`=0) is ignored unless `swPermit[0]`=1. A software write to the status word (`swSel`=1) is ignored unless `swPermit[1]`=1. Software never changes bit 31.
- R4: A processor reset (`cpuRstN`=0 for a cycle) clears control bits 30..23 and all status bits only while debugger mode is 0. With debugger mode 1 it leaves both words unchanged. Only `porRstN` clears the debugger-mode flag.
- R5: With internal mode (control bit 30) and debugger mode both 0, no event changes the status word.
- R6: When internal mode or debugger mode is 1, an event k with its enable bit set sets its status bit on the next clock edge. Event k is `evtIn[k]`, with k=0 instruction-complete, 1 branch-taken, 2 interrupt-taken, 3 trap, 4 address-compare-1. Its enable is control bit 27-k and its status bit is status bit 31-k. An event whose enable is 0 is ignored.
- R7: `dbgIrq` is 1 exactly when a status bit is set, internal mode is 1, `intEn` is 1 and debugger mode is 0. This includes status recorded earlier while `intEn` was 0.
- R8: `rstOutN` is 0 only when the reset-control field (control bits 29:28) equals 2'b10. The values 00, 01 and 11 leave it at 1.
- R9: When a debugger-port write and a software write target the same register in the same cycle, only the debugger-port write takes effect.
- R10: Status bits are write-one-to-clear. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R11: Control bits 22..0 and status bits 26..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on / debug reset, active low, asynchronous |
| cpuRstN | input | 1 | Processor reset, active low, sampled at the clock |
| swWrEn | input | 1 | Software write strobe |
| swSel | input | 1 | Software target: 0 control, 1 status |
| swWrData | input | 32 | Software write data |
| swPermit | input | 2 | Software permission under debugger mode: [0] control, [1] status |
| dbgWrEn | input | 1 | Debugger-port write strobe |
| dbgSel | input | 1 | Debugger target: 0 control, 1 status |
| dbgWrData | input | 32 | Debugger-port write data |
| evtIn | input | 5 | Event strobes, index k as in R6 |
| intEn | input | 1 | Processor debug-interrupt enable |
| ctrlOut | output | 32 | Control word |
| statusOut | output | 32 | Status word |
| dbgIrq | output | 1 | Debug interrupt request |
| rstOutN | output | 1 | Reset-out request, active low |

## Verification
The hardest situation to reach is a processor reset that arrives while the debugger owns the unit. For that case the stimulus must first set the debugger-mode flag with a write whose other bits would otherwise corrupt the word. It must then program the control fields from the debugger port and record an event. Only then does it pulse the processor reset, and it compares both words and the reset-out pin before and after. Same-cycle collisions come from one stimulus task that can drive both write ports and the event strobes on a single edge. The same task produces the simultaneous event-and-clear case.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  parameter int DATA_W  = 32;
  parameter int NUM_EVT = 5;

  // MSB-first field positions
  localparam int EDM_BIT = DATA_W - 1;
  localparam int IDM_BIT = DATA_W - 2;
  localparam int RSTF_HI = DATA_W - 3;
  localparam int EN_HI   = DATA_W - 5;
  // internal mode, 2-bit reset field, one enable per event
  localparam int LO_W    = 3 + NUM_EVT;

  localparam logic [1:0] RSTF_ASSERT = 2'b10;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} regSel_e;

  typedef struct packed {
    logic               loadEdm;
    logic               edmVal;
    logic               loadLo;
    logic [LO_W-1:0]    loWord;
    logic [NUM_EVT-1:0] clrMask;
    logic               wipe;
  } gateStrobe_t;
endpackage

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_gate_pkg::*;
(
  input  logic              cpuRstN,
  input  logic              swWrEn,
  input  logic              swSel,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [1:0]        swPermit,
  input  logic              dbgWrEn,
  input  logic              dbgSel,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic              edmNow,
  output gateStrobe_t       strb
);
  function automatic logic [NUM_EVT-1:0] pickClr(input logic [DATA_W-1:0] d);
    logic [NUM_EVT-1:0] m;
    for (int k = 0; k < NUM_EVT; k++) m[k] = d[DATA_W-1-k];
    return m;
  endfunction

  logic dbgCtrlHit, dbgStatHit, swCtrlOk, swStatOk;

  always_comb begin
    dbgCtrlHit = dbgWrEn && (dbgSel == SEL_CTRL);
    dbgStatHit = dbgWrEn && (dbgSel == SEL_STAT);
    // software loses to the debugger and is held off during processor reset
    swCtrlOk = swWrEn && (swSel == SEL_CTRL) && cpuRstN &&
               (!edmNow || swPermit[0]) && !dbgCtrlHit;
    swStatOk = swWrEn && (swSel == SEL_STAT) && cpuRstN &&
               (!edmNow || swPermit[1]) && !dbgStatHit;

    strb.loadEdm = dbgCtrlHit;
    strb.edmVal  = dbgWrData[EDM_BIT];
    strb.loadLo  = 1'b0;
    strb.loWord  = '0;
    if (dbgCtrlHit) begin
      // first entry into debugger mode leaves the other fields alone
      strb.loadLo = edmNow;
      strb.loWord = dbgWrData[IDM_BIT -: LO_W];
    end else if (swCtrlOk) begin
      strb.loadLo = 1'b1;
      strb.loWord = swWrData[IDM_BIT -: LO_W];
    end

    if (dbgStatHit)    strb.clrMask = pickClr(dbgWrData);
    else if (swStatOk) strb.clrMask = pickClr(swWrData);
    else               strb.clrMask = '0;

    strb.wipe = !cpuRstN && !edmNow;
  end
endmodule

// File: rtl/dbg_gate_dp.sv
module dbg_gate_dp
  import dbg_gate_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  gateStrobe_t        strb,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               intEn,
  output logic [DATA_W-1:0]  ctrlWord,
  output logic [DATA_W-1:0]  statWord,
  output logic               irqOut,
  output logic               rstOutN
);
  logic               edmQ;
  logic [LO_W-1:0]    loQ;
  logic [NUM_EVT-1:0] stQ, enVec, setMask;
  logic               idm;

  assign idm = loQ[LO_W-1];

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_en
    assign enVec[k] = loQ[NUM_EVT-1-k];
  end

  assign setMask = evtIn & enVec & {NUM_EVT{idm | edmQ}};

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      edmQ <= 1'b0;
      loQ  <= '0;
      stQ  <= '0;
    end else begin
      if (strb.loadEdm) edmQ <= strb.edmVal;
      if (strb.wipe)        loQ <= '0;
      else if (strb.loadLo) loQ <= strb.loWord;
      if (strb.wipe) stQ <= '0;
      else           stQ <= (stQ & ~strb.clrMask) | setMask;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EDM_BIT] = edmQ;
    ctrlWord[IDM_BIT -: LO_W] = loQ;
    statWord = '0;
    for (int k = 0; k < NUM_EVT; k++) statWord[DATA_W-1-k] = stQ[k];
  end

  assign irqOut  = (|stQ) && idm && intEn && !edmQ;
  assign rstOutN = !(loQ[LO_W-2 -: 2] == RSTF_ASSERT);
endmodule

// File: rtl/dbg_gate_top.sv
module dbg_gate_top
  import dbg_gate_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  logic               cpuRstN,
  input  logic               swWrEn,
  input  logic               swSel,
  input  logic [DATA_W-1:0]  swWrData,
  input  logic [1:0]         swPermit,
  input  logic               dbgWrEn,
  input  logic               dbgSel,
  input  logic [DATA_W-1:0]  dbgWrData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               intEn,
  output logic [DATA_W-1:0]  ctrlOut,
  output logic [DATA_W-1:0]  statusOut,
  output logic               dbgIrq,
  output logic               rstOutN
);
  gateStrobe_t strb;

  dbg_gate_ctrl u_ctrl (
    .cpuRstN(cpuRstN), .swWrEn(swWrEn), .swSel(swSel), .swWrData(swWrData),
    .swPermit(swPermit), .dbgWrEn(dbgWrEn), .dbgSel(dbgSel),
    .dbgWrData(dbgWrData), .edmNow(ctrlOut[EDM_BIT]), .strb(strb)
  );

  dbg_gate_dp u_dp (
    .clk(clk), .porRstN(porRstN), .strb(strb), .evtIn(evtIn), .intEn(intEn),
    .ctrlWord(ctrlOut), .statWord(statusOut), .irqOut(dbgIrq), .rstOutN(rstOutN)
  );
endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk
  import dbg_gate_pkg::*;
(
  input logic              clk,
  input logic              porRstN,
  input logic              cpuRstN,
  input logic              swWrEn,
  input logic              dbgWrEn,
  input logic              dbgSel,
  input logic [DATA_W-1:0] ctrlOut,
  input logic [DATA_W-1:0] statusOut,
  input logic              dbgIrq,
  input logic              rstOutN
);
  AST_EDM_DBG_ONLY: assert property (@(posedge clk) disable iff (!porRstN)
    (ctrlOut[EDM_BIT] != $past(ctrlOut[EDM_BIT])) |-> $past(dbgWrEn && dbgSel == SEL_CTRL)); // R1

  AST_CPU_RST_KEEP: assert property (@(posedge clk) disable iff (!porRstN)
    (!cpuRstN && ctrlOut[EDM_BIT] && !dbgWrEn && !swWrEn) |=> (ctrlOut == $past(ctrlOut))); // R4

  AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!porRstN)
    (!ctrlOut[EDM_BIT] && !ctrlOut[IDM_BIT]) |=> ((statusOut & ~$past(statusOut)) == '0)); // R5

  AST_NO_IRQ_DBG: assert property (@(posedge clk) disable iff (!porRstN)
    ctrlOut[EDM_BIT] |-> !dbgIrq); // R7

  AST_RSTOUT_CODE: assert property (@(posedge clk) disable iff (!porRstN)
    (ctrlOut[RSTF_HI -: 2] != RSTF_ASSERT) |-> rstOutN); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!porRstN)
    (ctrlOut[EN_HI-NUM_EVT:0] == '0) && (statusOut[DATA_W-1-NUM_EVT:0] == '0)); // R11
endmodule

bind dbg_gate_top dbg_gate_chk u_chk (
  .clk(clk), .porRstN(porRstN), .cpuRstN(cpuRstN), .swWrEn(swWrEn),
  .dbgWrEn(dbgWrEn), .dbgSel(dbgSel), .ctrlOut(ctrlOut),
  .statusOut(statusOut), .dbgIrq(dbgIrq), .rstOutN(rstOutN)
);

// File: tb/dbg_gate_top_bench.sv
module dbg_gate_top_bench;
  logic        clk = 1'b0;
  logic        porRstN, cpuRstN, swWrEn, swSel, dbgWrEn, dbgSel, intEn;
  logic [31:0] swWrData, dbgWrData;
  logic [1:0]  swPermit;
  logic [4:0]  evtIn;
  logic [31:0] ctrlOut, statusOut;
  logic        dbgIrq, rstOutN;
  int          totalCnt = 0;
  int          failCnt  = 0;

  always #10 clk = ~clk;

  dbg_gate_top u_dbg_gate_top (
    .clk(clk), .porRstN(porRstN), .cpuRstN(cpuRstN), .swWrEn(swWrEn),
    .swSel(swSel), .swWrData(swWrData), .swPermit(swPermit),
    .dbgWrEn(dbgWrEn), .dbgSel(dbgSel), .dbgWrData(dbgWrData),
    .evtIn(evtIn), .intEn(intEn), .ctrlOut(ctrlOut), .statusOut(statusOut),
    .dbgIrq(dbgIrq), .rstOutN(rstOutN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given stimulus, sampled at the following falling edge
  task automatic cycle(input logic sEn, input logic sS, input logic [31:0] sD,
                       input logic dEn, input logic dS, input logic [31:0] dD,
                       input logic [4:0] ev);
    @(negedge clk);
    swWrEn = sEn; swSel = sS; swWrData = sD;
    dbgWrEn = dEn; dbgSel = dS; dbgWrData = dD; evtIn = ev;
    @(negedge clk);
    swWrEn = 0; dbgWrEn = 0; evtIn = 0;
  endtask

  task automatic swWr(input logic s, input logic [31:0] d);
    cycle(1, s, d, 0, 0, 0, 0);
  endtask
  task automatic dbgWr(input logic s, input logic [31:0] d);
    cycle(0, 0, 0, 1, s, d, 0);
  endtask
  task automatic pulse(input logic [4:0] ev);
    cycle(0, 0, 0, 0, 0, 0, ev);
  endtask

  task automatic doPor();
    @(negedge clk);
    porRstN = 0; cpuRstN = 1; swWrEn = 0; dbgWrEn = 0; swSel = 0; dbgSel = 0;
    swWrData = 0; dbgWrData = 0; swPermit = 0; evtIn = 0; intEn = 0;
    @(negedge clk);
    porRstN = 1;
    @(negedge clk);
  endtask

  task automatic cpuReset();
    @(negedge clk); cpuRstN = 0;
    @(negedge clk); cpuRstN = 1;
  endtask

  task automatic tResetState();
    doPor();
    check("R11 ctrl after reset", ctrlOut, 32'h0);
    check("R11 status after reset", statusOut, 32'h0);
    check("R8 rstOutN after reset", {31'b0, rstOutN}, 32'h1);
    check("R7 irq after reset", {31'b0, dbgIrq}, 32'h0);
  endtask

  task automatic tSwNoEdm();
    doPor();
    swWr(0, 32'hFFFF_FFFF);
    check("R1 sw cannot set edm", ctrlOut, 32'h7F80_0000);
    check("R11 unused ctrl bits", ctrlOut & 32'h007F_FFFF, 32'h0);
    check("R8 field 11 no reset-out", {31'b0, rstOutN}, 32'h1);
  endtask

  task automatic tEdmEntry();
    doPor();
    swWr(0, 32'h4800_0000);
    dbgWr(0, 32'hFFFF_FFFF);
    check("R2 edm entry keeps fields", ctrlOut, 32'hC800_0000);
    swWr(0, 32'h0000_0000);
    check("R1 sw cannot clear edm", ctrlOut[31], 1'b1);
  endtask

  task automatic tPermit();
    doPor();
    dbgWr(0, 32'h8000_0000);
    swWr(0, 32'h4000_0000);
    check("R3 sw ctrl locked", ctrlOut, 32'h8000_0000);
    swPermit = 2'b01;
    swWr(0, 32'h4000_0000);
    check("R3 sw ctrl permitted", ctrlOut, 32'hC000_0000);
    dbgWr(0, 32'h8800_0000);
    pulse(5'b00001);
    check("R6 edm records event", statusOut, 32'h8000_0000);
    swWr(1, 32'h8000_0000);
    check("R3 sw status locked", statusOut, 32'h8000_0000);
    swPermit = 2'b11;
    swWr(1, 32'h8000_0000);
    check("R3 sw status permitted", statusOut, 32'h0);
  endtask

  task automatic tCpuReset();
    doPor();
    swWr(0, 32'h4F80_0000);
    pulse(5'b00100);
    check("R6 event before cpu reset", statusOut, 32'h2000_0000);
    cpuReset();
    check("R4 cpu reset clears ctrl", ctrlOut, 32'h0);
    check("R4 cpu reset clears status", statusOut, 32'h0);
    dbgWr(0, 32'h8000_0000);
    dbgWr(0, 32'hAF80_0000);
    pulse(5'b10000);
    check("R8 field 10 asserts reset-out", {31'b0, rstOutN}, 32'h0);
    cpuReset();
    check("R4 ctrl kept under edm", ctrlOut, 32'hAF80_0000);
    check("R4 status kept under edm", statusOut, 32'h0800_0000);
    doPor();
    check("R4 por clears edm", ctrlOut, 32'h0);
  endtask

  task automatic tGating();
    doPor();
    swWr(0, 32'h0F80_0000);
    pulse(5'b11111);
    check("R5 idle mode ignores events", statusOut, 32'h0);
    swWr(0, 32'h4A00_0000);
    pulse(5'b11111);
    check("R6 only enabled events set", statusOut, 32'hA000_0000);
  endtask

  task automatic tIrq();
    doPor();
    swWr(0, 32'h4800_0000);
    pulse(5'b00001);
    check("R7 no irq with intEn 0", {31'b0, dbgIrq}, 32'h0);
    @(negedge clk); intEn = 1; #1;
    check("R7 earlier status raises irq", {31'b0, dbgIrq}, 32'h1);
    dbgWr(0, 32'h8000_0000);
    check("R7 edm masks irq", {31'b0, dbgIrq}, 32'h0);
    intEn = 0;
  endtask

  task automatic tRstField();
    doPor();
    swWr(0, 32'h2000_0000);
    check("R8 field 10", {31'b0, rstOutN}, 32'h0);
    swWr(0, 32'h1000_0000);
    check("R8 field 01", {31'b0, rstOutN}, 32'h1);
    swWr(0, 32'h3000_0000);
    check("R8 field 11", {31'b0, rstOutN}, 32'h1);
    swWr(0, 32'h0);
    check("R8 field 00", {31'b0, rstOutN}, 32'h1);
  endtask

  task automatic tCollide();
    doPor();
    dbgWr(0, 32'h8000_0000);
    swPermit = 2'b11;
    cycle(1, 0, 32'h4000_0000, 1, 0, 32'h8800_0000, 0);
    check("R9 debugger wins on ctrl", ctrlOut, 32'h8800_0000);
  endtask

  task automatic tClear();
    doPor();
    swWr(0, 32'h4C00_0000);
    pulse(5'b00011);
    check("R6 two events", statusOut, 32'hC000_0000);
    cycle(1, 1, 32'hC000_0000, 0, 0, 0, 5'b00001);
    check("R10 set beats clear", statusOut, 32'h8000_0000);
    swWr(1, 32'h8000_0000);
    check("R10 w1c clears", statusOut, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    tResetState();
    tSwNoEdm();
    tEdmEntry();
    tPermit();
    tCpuReset();
    tGating();
    tIrq();
    tRstField();
    tCollide();
    tClear();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule